// File: doc/BRIEF.md
# Programmable Frequency Generator Bank

This block holds six programmable frequency generators that all run on one fast reference clock. Each generator chooses one of three source rate strobes, can be switched off, and divides the chosen strobe by a programmable ratio. Its output is a single-cycle tick enable in the reference domain, so downstream logic runs from the same clock and qualifies its work with the tick.

Configuration lives in two 32-bit words on a small synchronous write/read bus. Each word packs three generators in 10-bit slots. An elaboration-time mode parameter fixes one of two field encodings:

- **Legacy encoding.** A generator has its own on/off bit, picks one of two sources, and divides only by even ratios.
- **Extended encoding.** The two low slot bits form a source mux in which zero means off. A scale bit shared by all six generators allows any integer ratio, at half the maximum range. A resume strobe re-enables parked generators on the source they last used.

Ratios and sources change without runt ticks: a new setting is adopted only at the end of the division period in progress.

Top module: `freq_gen_bank`

## Requirements
- R1: After reset every tick output is low and both configuration words read back as zero.
- R2: In legacy encoding, a read returns the last value written to the addressed word, with bits 31:30 reading zero. Those two bits have no effect on any generator.
- R3: Generator a*3+k is configured by bits 10k+9 down to 10k of word a (a = 0 or 1, k = 0..2). Its tick is the only tick that the slot drives.
- R4: In legacy encoding, slot bit 1 enables the generator. While it is 0 the generator's tick stays low.
- R5: In legacy encoding, slot bit 0 selects the source: 0 takes source strobe 0 and 1 takes source strobe 1.
- R6: In legacy encoding, with D the 8-bit value in slot bits 9:2, the generator ticks once every (D+1)*2 source strobes (ratio 2 to 512).
- R7: In extended encoding, slot bits 1:0 are the source mux. Code 0 means off, with the tick held low. Code 1 takes strobe 2, code 2 takes strobe 0, and code 3 takes strobe 1.
- R8: In extended encoding, bit 30 of word 0 is the scale bit for all six generators and reads back. When it is 1 the ratio is D+1 (1 to 256). When it is 0 the ratio is (D+1)*2. Bit 30 of word 1 reads zero.
- R9: In extended encoding, a write with bit 31 set turns every slot of the addressed word that is written with mux code 0 into that slot's last non-zero mux code (code 1 after reset). Bit 31 reads zero.
- R10: Each tick is one cycle wide, and ratio 1 gives a tick every cycle. With an always-high source, the first tick after a write that enables a generator appears N+1 cycles after the write edge, where N is the ratio. This is because the divider restarts from zero.
- R11: A new ratio or source written while a generator runs takes effect only after the current period completes. That period ends on the old ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 1 | Word select, 0 or 1 |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read-back of the addressed word (combinational) |
| src_tick | input | 3 | Source rate strobes, one bit per source |
| tick | output | 6 | Tick enable per generator |

## Verification
The properties assume that each source strobe is a level sampled on the reference clock, and that the written ratio never decodes to zero, which the encodings cannot produce. They also assume that read-back compares one write with the next cycle only when the address is held. The stimulus changes bus and strobe inputs only on the falling edge. It derives strobes 1 and 2 from a free-running count, with periods of 2 and 3 cycles. It holds the address steady around every write it reads back.

// File: rtl/fgb_pkg.sv
package fgb_pkg;
   localparam int FGB_DATA_W  = 32;
   localparam int FGB_FIELD_W = 10;
   localparam int FGB_DIV_W   = 8;
   localparam int FGB_NUM_SRC = 3;

   // source strobe indices seen by a divider
   localparam logic [1:0] SRC_IDX_CPU  = 2'd0;
   localparam logic [1:0] SRC_IDX_AUX  = 2'd1;
   localparam logic [1:0] SRC_IDX_AUX2 = 2'd2;

   typedef enum logic [1:0] {
      MUX_OFF  = 2'd0,
      MUX_AUX2 = 2'd1,
      MUX_CPU  = 2'd2,
      MUX_AUX  = 2'd3
   } ext_mux_e;

   function automatic logic [1:0] ext_mux_to_src(input logic [1:0] code);
      logic [1:0] idx;
      case (ext_mux_e'(code))
         MUX_AUX2: idx = SRC_IDX_AUX2;
         MUX_CPU:  idx = SRC_IDX_CPU;
         MUX_AUX:  idx = SRC_IDX_AUX;
         default:  idx = SRC_IDX_CPU;
      endcase
      return idx;
   endfunction
endpackage

// File: rtl/fgb_cfg_regs.sv
module fgb_cfg_regs
   import fgb_pkg::*;
#(
   parameter bit EXT_MODE   = 1'b0,
   parameter int NUM_REG    = 2,
   parameter int PER_REG    = 3,
   parameter int DATA_W     = FGB_DATA_W,
   parameter int FIELD_W    = FGB_FIELD_W,
   parameter int DIV_W      = FGB_DIV_W,
   parameter int SCALE_POS  = 30,
   parameter int RESUME_POS = 31,
   localparam int NUM_GEN   = NUM_REG * PER_REG,
   localparam int NW        = DIV_W + 2,
   localparam int AW        = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [AW-1:0]                addr,
   input  logic [DATA_W-1:0]            wr_data,
   output logic [DATA_W-1:0]            rd_data,
   output logic [NUM_GEN-1:0]           cfg_en,
   output logic [NUM_GEN-1:0][1:0]      cfg_sel,
   output logic [NUM_GEN-1:0][NW-1:0]   cfg_ratio
);

   logic [FIELD_W-1:0] field_all [NUM_GEN];
   logic [DATA_W-1:0]  reg_word  [NUM_REG];
   logic               scale_q;

   // shared scale bit, extended encoding only
   generate
      if (EXT_MODE) begin : g_scale
         always_ff @(posedge clk) begin
            if (!rst_n)
               scale_q <= 1'b0;
            else if (wr_en && addr == '0)
               scale_q <= wr_data[SCALE_POS];
         end
      end else begin : g_noscale
         assign scale_q = 1'b0;
      end
   endgenerate

   generate
      for (genvar g = 0; g < NUM_GEN; g++) begin : g_slot
         localparam int RIDX = g / PER_REG;
         localparam int LSB  = (g % PER_REG) * FIELD_W;

         logic [FIELD_W-1:0] fld_q;
         logic [FIELD_W-1:0] wfld;
         logic               hit;
         logic [NW-1:0]      dplus;

         assign wfld  = wr_data[LSB +: FIELD_W];
         assign hit   = wr_en && (addr == AW'(RIDX));
         assign dplus = {2'b00, fld_q[FIELD_W-1:2]} + NW'(1);
         assign field_all[g] = fld_q;

         if (EXT_MODE) begin : g_ext
            logic [1:0] memo_q;   // last non-zero mux code
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  fld_q  <= '0;
                  memo_q <= 2'd1;
               end else if (hit) begin
                  if (wfld[1:0] == 2'd0 && wr_data[RESUME_POS])
                     fld_q <= {wfld[FIELD_W-1:2], memo_q};
                  else
                     fld_q <= wfld;
                  if (wfld[1:0] != 2'd0)
                     memo_q <= wfld[1:0];
               end
            end
            assign cfg_en[g]    = (fld_q[1:0] != 2'd0);
            assign cfg_sel[g]   = ext_mux_to_src(fld_q[1:0]);
            assign cfg_ratio[g] = scale_q ? dplus : {dplus[NW-2:0], 1'b0};
         end else begin : g_leg
            always_ff @(posedge clk) begin
               if (!rst_n)
                  fld_q <= '0;
               else if (hit)
                  fld_q <= wfld;
            end
            assign cfg_en[g]    = fld_q[1];
            assign cfg_sel[g]   = fld_q[0] ? SRC_IDX_AUX : SRC_IDX_CPU;
            assign cfg_ratio[g] = {dplus[NW-2:0], 1'b0};
         end
      end
   endgenerate

   always_comb begin
      for (int r = 0; r < NUM_REG; r++) begin
         reg_word[r] = '0;
         for (int k = 0; k < PER_REG; k++)
            reg_word[r][k*FIELD_W +: FIELD_W] = field_all[r*PER_REG + k];
      end
      reg_word[0][SCALE_POS] = scale_q;
   end

   assign rd_data = reg_word[addr];

endmodule

// File: rtl/fgb_divider.sv
module fgb_divider #(
   parameter int NW      = 10,
   parameter int NUM_SRC = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [1:0]         sel,
   input  logic [NW-1:0]      ratio,
   input  logic [NUM_SRC-1:0] src_tick,
   output logic               tick,
   output logic [NW-1:0]      act_n_o,
   output logic [NW-1:0]      cnt_o
);

   logic          run_q;
   logic [1:0]    sel_q;
   logic [NW-1:0] n_q;
   logic [NW-1:0] cnt_q;
   logic          tick_q;
   logic [3:0]    src_pad;
   logic          stick;
   logic          last;

   assign src_pad = 4'(src_tick);
   assign stick   = src_pad[sel_q];
   assign last    = (cnt_q == n_q - NW'(1));

   // settings are captured on start and at each period end only
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         sel_q  <= '0;
         n_q    <= NW'(2);
         cnt_q  <= '0;
         tick_q <= 1'b0;
      end else if (!en) begin
         run_q  <= 1'b0;
         cnt_q  <= '0;
         tick_q <= 1'b0;
      end else if (!run_q) begin
         run_q  <= 1'b1;
         cnt_q  <= '0;
         sel_q  <= sel;
         n_q    <= ratio;
         tick_q <= 1'b0;
      end else if (stick) begin
         if (last) begin
            tick_q <= 1'b1;
            cnt_q  <= '0;
            sel_q  <= sel;
            n_q    <= ratio;
         end else begin
            tick_q <= 1'b0;
            cnt_q  <= cnt_q + NW'(1);
         end
      end else begin
         tick_q <= 1'b0;
      end
   end

   assign tick    = tick_q;
   assign act_n_o = n_q;
   assign cnt_o   = cnt_q;

endmodule

// File: rtl/freq_gen_bank.sv
module freq_gen_bank
   import fgb_pkg::*;
#(
   parameter bit EXT_MODE   = 1'b0,
   parameter int NUM_REG    = 2,
   parameter int PER_REG    = 3,
   parameter int DATA_W     = FGB_DATA_W,
   parameter int FIELD_W    = FGB_FIELD_W,
   parameter int DIV_W      = FGB_DIV_W,
   parameter int NUM_SRC    = FGB_NUM_SRC,
   parameter int SCALE_POS  = 30,
   parameter int RESUME_POS = 31,
   localparam int NUM_GEN   = NUM_REG * PER_REG,
   localparam int NW        = DIV_W + 2,
   localparam int AW        = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [AW-1:0]      addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  rd_data,
   input  logic [NUM_SRC-1:0] src_tick,
   output logic [NUM_GEN-1:0] tick
);

   generate
      if (FIELD_W != DIV_W + 2) begin : g_bad_field
         $error("slot width must be divider width plus two");
      end
      if (PER_REG * FIELD_W > SCALE_POS || SCALE_POS >= DATA_W || RESUME_POS >= DATA_W
          || RESUME_POS == SCALE_POS) begin : g_bad_pos
         $error("slots overlap the control bits or exceed the word");
      end
      if (NUM_SRC < 3 || NUM_SRC > 4) begin : g_bad_src
         $error("source count must be 3 or 4");
      end
   endgenerate

   logic [NUM_GEN-1:0]         cfg_en;
   logic [NUM_GEN-1:0][1:0]    cfg_sel;
   logic [NUM_GEN-1:0][NW-1:0] cfg_ratio;
   logic [NUM_GEN-1:0][NW-1:0] div_n;
   logic [NUM_GEN-1:0][NW-1:0] div_cnt;

   fgb_cfg_regs #(
      .EXT_MODE   (EXT_MODE),
      .NUM_REG    (NUM_REG),
      .PER_REG    (PER_REG),
      .DATA_W     (DATA_W),
      .FIELD_W    (FIELD_W),
      .DIV_W      (DIV_W),
      .SCALE_POS  (SCALE_POS),
      .RESUME_POS (RESUME_POS)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .addr      (addr),
      .wr_data   (wr_data),
      .rd_data   (rd_data),
      .cfg_en    (cfg_en),
      .cfg_sel   (cfg_sel),
      .cfg_ratio (cfg_ratio)
   );

   generate
      for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
         fgb_divider #(
            .NW      (NW),
            .NUM_SRC (NUM_SRC)
         ) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (cfg_en[g]),
            .sel      (cfg_sel[g]),
            .ratio    (cfg_ratio[g]),
            .src_tick (src_tick),
            .tick     (tick[g]),
            .act_n_o  (div_n[g]),
            .cnt_o    (div_cnt[g])
         );
      end
   endgenerate

endmodule

// File: rtl/freq_gen_bank_chk.sv
module freq_gen_bank_chk #(
   parameter bit EXT_MODE = 1'b0,
   parameter int NUM_GEN  = 6,
   parameter int NW       = 10,
   parameter int AW       = 1,
   parameter int DATA_W   = 32,
   parameter int LOW_W    = 30
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_en,
   input logic [AW-1:0]              addr,
   input logic [DATA_W-1:0]          wr_data,
   input logic [DATA_W-1:0]          rd_data,
   input logic [NUM_GEN-1:0]         gen_en,
   input logic [NUM_GEN-1:0][NW-1:0] act_n,
   input logic [NUM_GEN-1:0][NW-1:0] cnt,
   input logic [NUM_GEN-1:0]         tick
);

   generate
      for (genvar g = 0; g < NUM_GEN; g++) begin : g_a
         // switched-off slot stays silent (R7 in extended encoding)
         assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !gen_en[g] |=> !tick[g]);

         assert_tick_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[g] && act_n[g] > NW'(1)) |=> !tick[g]);

         assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[g] < act_n[g]);

         if (EXT_MODE) begin : g_ext
            assert_ratio_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
               act_n[g] != '0);
         end else begin : g_leg
            assert_even_ratio_R6: assert property (@(posedge clk) disable iff (!rst_n)
               (act_n[g][0] == 1'b0) && (act_n[g] != '0));
         end
      end

      if (!EXT_MODE) begin : g_rb
         assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> ((addr != $past(addr)) ||
                       (rd_data == {{(DATA_W-LOW_W){1'b0}}, $past(wr_data[LOW_W-1:0])})));
      end
   endgenerate

endmodule

bind freq_gen_bank freq_gen_bank_chk #(
   .EXT_MODE (EXT_MODE),
   .NUM_GEN  (NUM_GEN),
   .NW       (NW),
   .AW       (AW),
   .DATA_W   (DATA_W),
   .LOW_W    (PER_REG * FIELD_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .addr    (addr),
   .wr_data (wr_data),
   .rd_data (rd_data),
   .gen_en  (cfg_en),
   .act_n   (div_n),
   .cnt     (div_cnt),
   .tick    (tick)
);

// File: tb/sim_freq_gen_bank.sv
module sim_freq_gen_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        b_wr    [2];
   logic        b_addr  [2];
   logic [31:0] b_wdata [2];
   logic [31:0] b_rdata [2];
   logic [5:0]  b_tick  [2];
   logic [2:0]  src_tick;
   int          errs = 0;
   int          checks = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   freq_gen_bank #(.EXT_MODE(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(b_wr[0]), .addr(b_addr[0]),
      .wr_data(b_wdata[0]), .rd_data(b_rdata[0]), .src_tick(src_tick), .tick(b_tick[0]));

   freq_gen_bank #(.EXT_MODE(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .wr_en(b_wr[1]), .addr(b_addr[1]),
      .wr_data(b_wdata[1]), .rd_data(b_rdata[1]), .src_tick(src_tick), .tick(b_tick[1]));

   // source strobes: 0 always high, 1 every 2nd cycle, 2 every 3rd cycle
   initial begin
      int ph;
      ph = 0;
      src_tick = 3'b001;
      forever begin
         @(negedge clk);
         ph = ph + 1;
         src_tick = {(ph % 3) == 0, ph[0], 1'b1};
      end
   end

   function automatic logic [31:0] lf(input int d, input int en, input int sel);
      return 32'((d << 2) | (en << 1) | sel);
   endfunction

   function automatic logic [31:0] ef(input int d, input int mux);
      return 32'((d << 2) | mux);
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int u, input int a, input logic [31:0] d);
      b_wr[u] = 1'b1;
      b_addr[u] = 1'(a);
      b_wdata[u] = d;
      @(posedge clk);
      @(negedge clk);
      b_wr[u] = 1'b0;
   endtask

   task automatic rd(input int u, input int a, output logic [31:0] d);
      b_addr[u] = 1'(a);
      #1;
      d = b_rdata[u];
   endtask

   task automatic wait_tick(input int u, input int g, input int lim,
                            output int j, output logic [5:0] oth);
      j = 0;
      oth = '0;
      for (int i = 1; i <= lim && j == 0; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (b_tick[u][g]) j = i;
         else oth = oth | (b_tick[u] & ~(6'b1 << g));
      end
   endtask

   task automatic gap(input int u, input int g, input int lim, output int gp);
      int t;
      logic [5:0] o;
      wait_tick(u, g, lim, t, o);
      if (t == 0) gp = 0;
      else wait_tick(u, g, lim, gp, o);
   endtask

   task automatic quiet(input int u, input int n, output int cnt);
      cnt = 0;
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
         cnt = cnt + $countones(b_tick[u]);
      end
   endtask

   // park every slot of the word (keeping the scale bit), then write it
   task automatic restart(input int u, input int a, input logic [31:0] d);
      wr(u, a, d & 32'h4000_0000);
      idle(3);
      wr(u, a, d);
   endtask

   initial begin
      logic [31:0] v;
      logic [5:0]  o;
      int j, gp, q;
      b_wr[0] = 1'b0; b_wr[1] = 1'b0;
      b_addr[0] = 1'b0; b_addr[1] = 1'b0;
      b_wdata[0] = '0; b_wdata[1] = '0;
      idle(5);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      for (int u = 0; u < 2; u++) begin
         chk(b_tick[u] == 6'd0, "R1 ticks", b_tick[u], 0);
         for (int a = 0; a < 2; a++) begin
            rd(u, a, v);
            chk(v == 32'd0, "R1 readback", v, 0);
         end
      end

      // R2 legacy readback and ignored top bits
      wr(0, 1, 32'hD5A5_A5A5);
      rd(0, 1, v);
      chk(v == 32'h15A5_A5A5, "R2 readback word1", v, 32'h15A5_A5A5);
      wr(0, 0, 32'hFFFF_FFFF);
      rd(0, 0, v);
      chk(v == 32'h3FFF_FFFF, "R2 readback word0", v, 32'h3FFF_FFFF);
      wr(0, 1, 32'd0);
      restart(0, 0, 32'hC000_0000 | lf(0, 1, 0));
      gap(0, 0, 50, gp);
      chk(gp == 2, "R2 top bits no effect", gp, 2);

      // R6 / R10 legacy ratio sweep on an always-high source
      for (int d = 0; d <= 12; d++) begin
         int dd;
         dd = (d == 12) ? 255 : d;
         restart(0, 0, lf(dd, 1, 0));
         wait_tick(0, 0, 1200, j, o);
         chk(j == 2 * (dd + 1) + 1, "R10 first tick", j, 2 * (dd + 1) + 1);
         wait_tick(0, 0, 1200, gp, o);
         chk(gp == 2 * (dd + 1), "R6 period", gp, 2 * (dd + 1));
      end

      // R3 slot placement
      for (int g = 0; g < 6; g++) begin
         wr(0, 0, 32'd0);
         wr(0, 1, 32'd0);
         idle(3);
         wr(0, g / 3, lf(g, 1, 0) << (10 * (g % 3)));
         wait_tick(0, g, 200, j, o);
         chk(j == 2 * (g + 1) + 1, "R3 slot first tick", j, 2 * (g + 1) + 1);
         wait_tick(0, g, 200, gp, o);
         chk(gp == 2 * (g + 1) && o == 6'd0, "R3 slot period/isolation", gp, 2 * (g + 1));
      end
      wr(0, 1, 32'd0);

      // R5 legacy source select (strobe 1 has period 2)
      restart(0, 0, lf(1, 1, 1));
      gap(0, 0, 100, gp);
      chk(gp == 8, "R5 source 1", gp, 8);
      restart(0, 0, lf(1, 1, 0));
      gap(0, 0, 100, gp);
      chk(gp == 4, "R5 source 0", gp, 4);
      restart(0, 0, lf(0, 1, 1) << 20);
      gap(0, 2, 100, gp);
      chk(gp == 4, "R5 source 1 slot 2", gp, 4);

      // R4 legacy enable bit
      restart(0, 0, lf(0, 0, 0) | (lf(0, 0, 1) << 10));
      quiet(0, 40, q);
      chk(q == 0, "R4 enable low", q, 0);
      wr(0, 0, lf(0, 1, 0));
      idle(10);
      wr(0, 0, lf(0, 0, 0));
      idle(1);
      quiet(0, 40, q);
      chk(q == 0, "R4 switched off while running", q, 0);

      // R11 change lands at period end
      restart(0, 0, lf(3, 1, 0));
      wait_tick(0, 0, 100, j, o);
      wr(0, 0, lf(0, 1, 0));
      wait_tick(0, 0, 100, j, o);
      chk(j == 7, "R11 old period completes", j, 7);
      wait_tick(0, 0, 100, gp, o);
      chk(gp == 2, "R11 new ratio after", gp, 2);
      wr(0, 0, 32'd0);

      // R7 extended mux codes, scale on, D=1 (ratio 2)
      restart(1, 0, 32'h4000_0000 | ef(1, 2));
      rd(1, 0, v);
      chk(v == (32'h4000_0000 | ef(1, 2)), "R8 scale readback", v, 32'h4000_0000 | ef(1, 2));
      gap(1, 0, 100, gp);
      chk(gp == 2, "R7 code 2 strobe 0", gp, 2);
      restart(1, 0, 32'h4000_0000 | ef(1, 3));
      gap(1, 0, 100, gp);
      chk(gp == 4, "R7 code 3 strobe 1", gp, 4);
      restart(1, 0, 32'h4000_0000 | ef(1, 1));
      gap(1, 0, 100, gp);
      chk(gp == 6, "R7 code 1 strobe 2", gp, 6);
      restart(1, 0, 32'h4000_0000 | ef(1, 0));
      quiet(1, 40, q);
      chk(q == 0, "R7 code 0 off", q, 0);

      // R8 / R10 scaled sweep, ratio D+1
      for (int d = 0; d <= 12; d++) begin
         int dd;
         dd = (d == 12) ? 255 : d;
         restart(1, 0, 32'h4000_0000 | ef(dd, 2));
         wait_tick(1, 0, 600, j, o);
         chk(j == dd + 2, "R10 scaled first tick", j, dd + 2);
         wait_tick(1, 0, 600, gp, o);
         chk(gp == dd + 1, "R8 scaled period", gp, dd + 1);
      end
      // R8 unscaled ratio (D+1)*2
      for (int d = 0; d <= 5; d++) begin
         restart(1, 0, ef(d, 2));
         wait_tick(1, 0, 100, j, o);
         chk(j == 2 * (d + 1) + 1, "R8 unscaled first tick", j, 2 * (d + 1) + 1);
      end
      // R8 word 0 scale governs word 1 slots; word 1 bit 30 not stored
      wr(1, 0, 32'h4000_0000);
      restart(1, 1, 32'h4000_0000 | ef(2, 2));
      rd(1, 1, v);
      chk(v == ef(2, 2), "R8 word1 bit30", v, ef(2, 2));
      gap(1, 3, 100, gp);
      chk(gp == 3, "R8 shared scale on", gp, 3);
      wr(1, 0, 32'd0);
      gap(1, 3, 100, gp);
      chk(gp == 6, "R8 shared scale off", gp, 6);
      wr(1, 1, 32'd0);

      // R9 resume restores last non-zero code
      restart(1, 0, 32'h4000_0000 | ef(1, 3));
      wr(1, 0, 32'h4000_0000 | ef(1, 0));
      rd(1, 0, v);
      chk(v == (32'h4000_0000 | ef(1, 0)), "R9 parked readback", v, 32'h4000_0000 | ef(1, 0));
      quiet(1, 30, q);
      chk(q == 0, "R9 parked quiet", q, 0);
      wr(1, 0, 32'hC000_0000 | ef(1, 0));
      rd(1, 0, v);
      chk(v == (32'h4000_0000 | ef(1, 3) | (32'd1 << 10) | (32'd1 << 20)),
          "R9 resumed readback", v, 32'h4000_0000 | ef(1, 3) | (32'd1 << 10) | (32'd1 << 20));
      gap(1, 0, 100, gp);
      chk(gp == 4, "R9 resumed source", gp, 4);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog R10 actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule